// File: doc/BRIEF.md
# Virtual Address Segment Checker

This purely combinational unit sits between address generation and memory access. It takes a 32-bit virtual address and places it in one of four segments. The segments are: a user region that goes through the TLB, two kernel windows that map straight onto low physical memory (one cached, one uncached), and a kernel region that goes through the TLB. For each access it produces the physical address and a cacheable flag, or it reports a fault with an exception code. The inputs it uses are the access kind, the access size, the current privilege mode and the result of a TLB lookup that is done elsewhere.

When a fault is reported, the unit also says which handler entry should take it. A miss in the user region with no matching entry goes to the fast refill entry. An entry that is present but not valid, or a miss in the mapped kernel region, goes to the general entry. Stores through an entry that is not writable are reported as write-protection faults. The TLB array and the update of exception state are not part of this unit.

Top module: `vaseg_check`

## Requirements
- R1: An address with bit 31 clear is user space and goes through the TLB. When the lookup hits with a valid entry, and for a store the entry is also dirty, there is no fault. In that case paddr = {tlbPfn, vaddr[11:0]} and cacheable = !tlbNoCache, in both user and kernel mode.
- R2: In kernel mode, addresses 0x80000000 to 0x9FFFFFFF map directly: paddr is vaddr with bits 31:29 cleared and cacheable = 1.
- R3: In kernel mode, addresses 0xA0000000 to 0xBFFFFFFF map directly with bits 31:29 cleared and cacheable = 0. All TLB inputs have no effect on the outputs for either direct window.
- R4: In kernel mode, addresses 0xC0000000 to 0xFFFFFFFF go through the TLB with the same translation, cacheability and fault rules as R1.
- R5: In user mode (userMode = 1), any address with bit 31 set faults. The code is 4 for fetch or load and 5 for store.
- R6: accKind is encoded 0 fetch, 1 load, 2 store, 3 load. accSize is encoded 0 byte, 1 half, 2 word, 3 word. A fetch is always checked as a word. A half access with bit 0 set, or a word access with bits 1:0 not zero, faults with code 4 for fetch or load and 5 for store. A byte access is never misaligned.
- R7: An address error (R5 or R6) takes priority over every TLB fault. In that case the code is 4 or 5 and refillVec = 0, whatever the TLB inputs are.
- R8: A TLB-mapped access whose lookup misses (tlbHit = 0) or hits an entry with tlbValid = 0 faults. The code is 2 for fetch or load and 3 for store.
- R9: refillVec = 1 exactly when a user-space access without an address error has tlbHit = 0. A hit on an invalid entry, or any miss in the mapped kernel region, gives refillVec = 0.
- R10: A store that hits a valid entry with tlbDirty = 0 faults with code 1. Loads and fetches through the same entry do not fault.
- R11: When fault = 1, paddr = 0 and cacheable = 0. When fault = 0, excCode = 0 and refillVec = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr | input | 32 | Virtual address of the access |
| accKind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| accSize | input | 2 | Access size: 0 byte, 1 half, 2 or 3 word |
| userMode | input | 1 | 1 when the processor runs in user mode |
| tlbHit | input | 1 | A matching TLB entry exists |
| tlbValid | input | 1 | Valid bit of the matching entry |
| tlbDirty | input | 1 | Write-enable bit of the matching entry |
| tlbNoCache | input | 1 | Uncached bit of the matching entry |
| tlbPfn | input | 20 | Physical page number of the matching entry |
| paddr | output | 32 | Translated physical address, 0 on fault |
| cacheable | output | 1 | Access may be cached |
| fault | output | 1 | Access raises an exception |
| excCode | output | 4 | Exception code: 1 write-protect, 2/3 TLB miss load/store, 4/5 address error load/store |
| refillVec | output | 1 | Fault goes to the fast refill entry |

## Verification
Directed vectors run one address in each segment under both privilege modes. This separates wrong segment boundaries from wrong privilege checks. Absent and invalid entries are applied to the same user and kernel-mapped addresses, which shows whether the refill entry is chosen only for an absent entry in user space. Misaligned and privileged addresses are combined with TLB misses to expose a wrong fault priority, and dirty-clear entries are tried under store, load and fetch. Constrained random vectors spread over all segments, sizes and TLB flag combinations then exercise the remaining combinations against a reference model in the bench.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

  typedef enum logic [1:0] {
    SEG_USER     = 2'd0,
    SEG_KCACHED  = 2'd1,
    SEG_KUNCACHE = 2'd2,
    SEG_KMAPPED  = 2'd3
  } segT;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } sizeT;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [3:0] EXC_NONE = 4'd0;
  localparam logic [3:0] EXC_MOD  = 4'd1;
  localparam logic [3:0] EXC_TLBL = 4'd2;
  localparam logic [3:0] EXC_TLBS = 4'd3;
  localparam logic [3:0] EXC_ADEL = 4'd4;
  localparam logic [3:0] EXC_ADES = 4'd5;

  // strobes from the control to the datapath
  typedef struct packed {
    logic squash;       // fault: drive a quiet address
    logic directMap;    // strip the window bits instead of using the TLB
    logic directCached; // cacheability for a direct window
  } xlateStrobeT;

endpackage

// File: rtl/vaseg_ctrl.sv
module vaseg_ctrl
  import vaseg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accSize,
  input  logic              userMode,
  input  logic              tlbHit,
  input  logic              tlbValid,
  input  logic              tlbDirty,
  output xlateStrobeT       strobe,
  output logic              fault,
  output logic [3:0]        excCode,
  output logic              refillVec
);

  localparam int TOP = ADDR_W - 1;

  segT  seg;
  sizeT effSize;
  logic isStore;
  logic isFetch;
  logic misaligned;
  logic privErr;
  logic addrErr;
  logic mappedSeg;
  logic tlbMiss;
  logic modErr;

  // segment from the top three address bits
  always_comb begin
    if (!vaddr[TOP])                 seg = SEG_USER;
    else if (vaddr[TOP-1])           seg = SEG_KMAPPED;
    else if (vaddr[TOP-2])           seg = SEG_KUNCACHE;
    else                             seg = SEG_KCACHED;
  end

  always_comb begin
    isStore   = (accKind == KIND_STORE);
    isFetch   = (accKind == KIND_FETCH);
    effSize   = isFetch ? SZ_WORD : sizeT'(accSize);
    unique case (effSize)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = vaddr[0];
      default: misaligned = (vaddr[1:0] != 2'b00);
    endcase
    privErr   = userMode && (seg != SEG_USER);
    addrErr   = misaligned || privErr;
    mappedSeg = (seg == SEG_USER) || (seg == SEG_KMAPPED);
    tlbMiss   = mappedSeg && (!tlbHit || !tlbValid);
    modErr    = mappedSeg && isStore && tlbHit && tlbValid && !tlbDirty;
  end

  // fault priority: address error, then miss, then write protect
  always_comb begin
    fault     = 1'b1;
    refillVec = 1'b0;
    if (addrErr) begin
      excCode = isStore ? EXC_ADES : EXC_ADEL;
    end else if (tlbMiss) begin
      excCode   = isStore ? EXC_TLBS : EXC_TLBL;
      refillVec = (seg == SEG_USER) && !tlbHit;
    end else if (modErr) begin
      excCode = EXC_MOD;
    end else begin
      excCode = EXC_NONE;
      fault   = 1'b0;
    end
  end

  always_comb begin
    strobe.squash       = fault;
    strobe.directMap    = !mappedSeg;
    strobe.directCached = (seg == SEG_KCACHED);
  end

  always_comb begin
    a_r9_refill_user_absent: assert (!refillVec || (fault && !vaddr[TOP] && !tlbHit))
      else $error("refill entry chosen outside an absent user miss");
    a_r11_quiet_code: assert (fault || (excCode == EXC_NONE && !refillVec))
      else $error("code or refill raised without a fault");
    a_r5_user_kernel: assert (!(userMode && vaddr[TOP]) ||
                              (fault && (excCode == EXC_ADEL || excCode == EXC_ADES)))
      else $error("user access to kernel space not an address error");
    a_r7_addr_first: assert (!(fault && excCode >= EXC_ADEL) || !refillVec)
      else $error("address error routed to refill entry");
  end

endmodule

// File: rtl/vaseg_datapath.sv
module vaseg_datapath
  import vaseg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 3
) (
  input  logic [ADDR_W-1:0]           vaddr,
  input  logic [ADDR_W-PAGE_BITS-1:0] tlbPfn,
  input  logic                        tlbNoCache,
  input  xlateStrobeT                 strobe,
  output logic [ADDR_W-1:0]           paddr,
  output logic                        cacheable
);

  localparam int LOW_W = ADDR_W - WIN_BITS;

  logic [ADDR_W-1:0] directAddr;
  logic [ADDR_W-1:0] mappedAddr;

  always_comb begin
    directAddr = {{WIN_BITS{1'b0}}, vaddr[LOW_W-1:0]};
    mappedAddr = {tlbPfn, vaddr[PAGE_BITS-1:0]};
    if (strobe.squash) begin
      paddr     = '0;
      cacheable = 1'b0;
    end else if (strobe.directMap) begin
      paddr     = directAddr;
      cacheable = strobe.directCached;
    end else begin
      paddr     = mappedAddr;
      cacheable = !tlbNoCache;
    end
  end

  always_comb begin
    a_r2_window_cleared: assert (strobe.squash || !strobe.directMap ||
                                 paddr[ADDR_W-1 -: WIN_BITS] == '0)
      else $error("direct window bits not cleared");
    a_r3_uncached_window: assert (!strobe.directMap || strobe.directCached || !cacheable)
      else $error("uncached window reported cacheable");
    a_r11_squash_quiet: assert (!strobe.squash || (paddr == '0 && !cacheable))
      else $error("faulting access drove an address");
  end

endmodule

// File: rtl/vaseg_check.sv
module vaseg_check
  import vaseg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int PFN_W    = ADDR_W - PAGE_BITS
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accKind,
  input  logic [1:0]        accSize,
  input  logic              userMode,
  input  logic              tlbHit,
  input  logic              tlbValid,
  input  logic              tlbDirty,
  input  logic              tlbNoCache,
  input  logic [PFN_W-1:0]  tlbPfn,
  output logic [ADDR_W-1:0] paddr,
  output logic              cacheable,
  output logic              fault,
  output logic [3:0]        excCode,
  output logic              refillVec
);

  xlateStrobeT strobe;

  vaseg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .vaddr     (vaddr),
    .accKind   (accKind),
    .accSize   (accSize),
    .userMode  (userMode),
    .tlbHit    (tlbHit),
    .tlbValid  (tlbValid),
    .tlbDirty  (tlbDirty),
    .strobe    (strobe),
    .fault     (fault),
    .excCode   (excCode),
    .refillVec (refillVec)
  );

  vaseg_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) uData (
    .vaddr      (vaddr),
    .tlbPfn     (tlbPfn),
    .tlbNoCache (tlbNoCache),
    .strobe     (strobe),
    .paddr      (paddr),
    .cacheable  (cacheable)
  );

endmodule

// File: tb/vaseg_check_test.sv
module vaseg_check_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] vaddr;
  logic [1:0]  accKind, accSize;
  logic        userMode, tlbHit, tlbValid, tlbDirty, tlbNoCache;
  logic [19:0] tlbPfn;
  logic [31:0] paddr;
  logic        cacheable, fault, refillVec;
  logic [3:0]  excCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  vaseg_check uut (
    .vaddr(vaddr), .accKind(accKind), .accSize(accSize), .userMode(userMode),
    .tlbHit(tlbHit), .tlbValid(tlbValid), .tlbDirty(tlbDirty),
    .tlbNoCache(tlbNoCache), .tlbPfn(tlbPfn), .paddr(paddr),
    .cacheable(cacheable), .fault(fault), .excCode(excCode), .refillVec(refillVec)
  );

  // expected outputs packed as {paddr, cacheable, fault, excCode, refill}
  function automatic logic [38:0] refModel(
      input logic [31:0] va, input logic [1:0] kind, input logic [1:0] size,
      input logic um, input logic hit, input logic vld, input logic dty,
      input logic nc, input logic [19:0] pfn);
    logic st, unal, priv, kmap, user, dir;
    logic [1:0] sz;
    st   = (kind == 2'd2);
    sz   = (kind == 2'd0) ? 2'd2 : size;
    unal = (sz == 2'd1) ? va[0] : (sz >= 2'd2) ? (va[1:0] != 0) : 1'b0;
    user = !va[31];
    kmap = va[31] && va[30];
    dir  = !user && !kmap;
    priv = um && va[31];
    if (unal || priv)                 return {32'd0, 1'b0, 1'b1, st ? 4'd5 : 4'd4, 1'b0};
    if (!dir && (!hit || !vld))       return {32'd0, 1'b0, 1'b1, st ? 4'd3 : 4'd2, user && !hit};
    if (!dir && st && !dty)           return {32'd0, 1'b0, 1'b1, 4'd1, 1'b0};
    if (dir)                          return {3'b000, va[28:0], !va[29], 1'b0, 4'd0, 1'b0};
    return {pfn, va[11:0], !nc, 1'b0, 4'd0, 1'b0};
  endfunction

  function automatic string reqTag(input logic [31:0] va, input logic [1:0] kind,
      input logic [1:0] size, input logic um, input logic hit, input logic vld);
    logic [1:0] sz;
    sz = (kind == 2'd0) ? 2'd2 : size;
    if (um && va[31]) return "R5";
    if ((sz == 2'd1 && va[0]) || (sz >= 2'd2 && va[1:0] != 0)) return "R6";
    if (va[31:29] == 3'b100) return "R2";
    if (va[31:29] == 3'b101) return "R3";
    if (!hit || !vld) return va[31] ? "R8" : "R9";
    return va[31] ? "R4" : "R1";
  endfunction

  task automatic apply(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] size,
      input logic um, input logic hit, input logic vld, input logic dty, input logic nc,
      input logic [19:0] pfn, input string tag);
    logic [38:0] exp, got;
    @(negedge clk);
    vaddr = va; accKind = kind; accSize = size; userMode = um;
    tlbHit = hit; tlbValid = vld; tlbDirty = dty; tlbNoCache = nc; tlbPfn = pfn;
    #1;
    exp = refModel(va, kind, size, um, hit, vld, dty, nc, pfn);
    got = {paddr, cacheable, fault, excCode, refillVec};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s va=%h kind=%0d size=%0d um=%0b actual=%h expected=%h",
               tag, va, kind, size, um, got, exp);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0C0D);
    vaddr = 0; accKind = 0; accSize = 0; userMode = 0;
    tlbHit = 0; tlbValid = 0; tlbDirty = 0; tlbNoCache = 0; tlbPfn = 0;
    repeat (2) @(posedge clk);
    // initial vector: kernel fetch at 0, absent entry
    apply(32'h0000_0000, 0, 2, 0, 0, 0, 0, 0, 20'h0, "R9");
    // R1 user hit both modes, cached and uncached
    apply(32'h1234_5678, 1, 2, 1, 1, 1, 0, 0, 20'hABCDE, "R1");
    apply(32'h7FFF_FFFF, 1, 0, 0, 1, 1, 1, 1, 20'h00F0F, "R1");
    apply(32'h0040_0004, 2, 2, 1, 1, 1, 1, 0, 20'h12345, "R1");
    // R2 and R3 direct windows, TLB inputs varied
    apply(32'h8000_0000, 0, 2, 0, 0, 0, 0, 1, 20'hFFFFF, "R2");
    apply(32'h9FFF_FFFC, 2, 2, 0, 1, 1, 0, 1, 20'h11111, "R2");
    apply(32'hA000_0000, 1, 2, 0, 0, 0, 0, 0, 20'h22222, "R3");
    apply(32'hBFFF_FFFE, 2, 1, 0, 1, 0, 1, 0, 20'h33333, "R3");
    // R4 kernel mapped
    apply(32'hC000_1000, 1, 2, 0, 1, 1, 0, 1, 20'h55555, "R4");
    apply(32'hFFFF_F003, 1, 0, 0, 1, 1, 1, 0, 20'h66666, "R4");
    // R5 user touching kernel space
    apply(32'h8000_0000, 1, 2, 1, 1, 1, 1, 0, 20'h1, "R5");
    apply(32'hA000_0010, 2, 2, 1, 1, 1, 1, 0, 20'h1, "R5");
    apply(32'hC000_0000, 0, 2, 1, 0, 0, 0, 0, 20'h1, "R5");
    // R6 alignment, fetch always word
    apply(32'h0000_1001, 1, 1, 0, 1, 1, 1, 0, 20'h7, "R6");
    apply(32'h0000_1002, 2, 2, 0, 1, 1, 1, 0, 20'h7, "R6");
    apply(32'h0000_1002, 1, 1, 0, 1, 1, 1, 0, 20'h7, "R6");
    apply(32'h0000_1001, 0, 0, 0, 1, 1, 1, 0, 20'h7, "R6");
    apply(32'h8000_0003, 3, 3, 0, 1, 1, 1, 0, 20'h7, "R6");
    // R7 address error beats absent entry
    apply(32'h0000_2002, 2, 2, 0, 0, 0, 0, 0, 20'h7, "R7");
    apply(32'hC000_0000, 1, 2, 1, 0, 0, 0, 0, 20'h7, "R7");
    // R8 / R9 misses
    apply(32'h0000_3000, 2, 2, 0, 0, 0, 0, 0, 20'h7, "R9");
    apply(32'h0000_3000, 1, 2, 1, 1, 0, 1, 0, 20'h7, "R9");
    apply(32'hC000_3000, 1, 2, 0, 0, 0, 0, 0, 20'h7, "R8");
    apply(32'hE000_3000, 2, 2, 0, 1, 0, 1, 0, 20'h7, "R8");
    // R10 write protection
    apply(32'h0000_4000, 2, 2, 1, 1, 1, 0, 0, 20'h9, "R10");
    apply(32'h0000_4000, 1, 2, 1, 1, 1, 0, 0, 20'h9, "R10");
    apply(32'h0000_4000, 0, 2, 1, 1, 1, 0, 0, 20'h9, "R10");
    apply(32'hD000_4000, 2, 0, 0, 1, 1, 0, 0, 20'h9, "R10");
    // R11 covered throughout; random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] va;
      logic [1:0] k, s;
      logic u, h, v;
      va = $urandom();
      if ($urandom_range(3) != 0) va[1:0] = 2'b00;
      k = 2'($urandom_range(3)); s = 2'($urandom_range(3));
      u = 1'($urandom_range(1)); h = 1'($urandom_range(1)); v = 1'($urandom_range(1));
      apply(va, k, s, u, h, v, 1'($urandom_range(1)), 1'($urandom_range(1)),
            20'($urandom()), reqTag(va, k, s, u, h, v));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule